// File: doc/BRIEF.md
# Grouped Interrupt Priority Signaller

This block serves a single CPU interface of an interrupt controller. Each cycle it looks at every interrupt source and keeps those that are pending, enabled and aimed at this CPU. Among them it picks the most urgent one, where a smaller priority number means more urgent. It then decides whether the CPU should see its normal interrupt line, its fast interrupt line, or neither.

The routing depends on four things: the winner's group (0 or 1), group enables at the distributor level, group enables at the CPU-interface level, and a fast-interrupt enable bit. Two thresholds gate the decision. The priority mask decides whether the winner is reported as the pending interrupt. The running priority decides whether a line is raised at all.

Selection is purely combinational. The two lines and the pending ID come out of registers, so they follow the inputs with one cycle of latency.

Top module: `psig_top`

## Requirements
- R1: While reset (`rst_n` low) is sampled at a rising edge, the next state is `irq_o`=0, `fiq_o`=0 and `pend_id_o`=1023.
- R2: A source takes part in selection only when its `src_pending`, `src_enable` and `src_target` bits are all 1.
- R3: Among the sources taking part, the one with the numerically smallest `src_prio` field wins. Source i uses bits [8i+7:8i]. On a tie, the lower source index wins.
- R4: When some group is enabled at both levels, `pend_id_o` becomes the winner's index if the winner's priority is strictly below `prio_mask`. Otherwise it becomes 1023, which also covers the case of no source taking part.
- R5: A line is raised only when the winner's priority is strictly below both `prio_mask` and `run_prio`.
- R6: With group bit g (`src_group`: 0 selects group 0, 1 selects group 1), a line is raised only if both the distributor enable and the CPU-interface enable of group g are 1.
- R7: A group-0 winner with `cpu_fast_en`=1 raises `fiq_o`. Any other raised winner raises `irq_o`. The two lines are never 1 together, and the line not chosen is 0.
- R8: If the distributor has both group enables at 0, or the CPU interface has both at 0, both lines go low and `pend_id_o` keeps its value.
- R9: The outputs reflect the inputs sampled at the previous rising edge. There is exactly one register stage and no combinational path from input to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pending | input | NUM_SRC | Per-source pending flag |
| src_enable | input | NUM_SRC | Per-source enable flag |
| src_target | input | NUM_SRC | Per-source flag: source is aimed at this CPU |
| src_group | input | NUM_SRC | Per-source group bit (0 or 1) |
| src_prio | input | 8*NUM_SRC | Packed 8-bit priorities, source i at [8i+7:8i] |
| dist_en_g0 | input | 1 | Distributor enable for group 0 |
| dist_en_g1 | input | 1 | Distributor enable for group 1 |
| cpu_en_g0 | input | 1 | CPU-interface enable for group 0 |
| cpu_en_g1 | input | 1 | CPU-interface enable for group 1 |
| cpu_fast_en | input | 1 | Send group-0 winners to the fast line |
| prio_mask | input | 8 | CPU priority mask (strict threshold) |
| run_prio | input | 8 | Current running priority (0xFF when idle) |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| pend_id_o | output | 10 | Current pending source index, 1023 if none |

## Verification
Every result (`irq_o`, `fiq_o`, `pend_id_o`) is due exactly one rising edge after the inputs that cause it. The bench changes inputs on the falling edge, lets one rising edge pass, and samples at the following falling edge. A dedicated latency scenario also samples just before that rising edge, where the old values must still hold, and again just after it, where the new values must already be present. Reset results are sampled the same way, one edge after the reset level is applied.

// File: rtl/psig_pkg.sv
// Package: shared constants and the candidate record used by the
// priority signaller. Assumes 8-bit priorities and 10-bit source IDs.
package psig_pkg;
    localparam int PRIO_W  = 8;
    localparam int CPRIO_W = PRIO_W + 1;   // one extra bit for the "none" sentinel
    localparam int ID_W    = 10;
    localparam logic [ID_W-1:0]    SPURIOUS_ID = 10'd1023;
    localparam logic [CPRIO_W-1:0] NO_PRIO     = 9'h100;

    typedef struct packed {
        logic [CPRIO_W-1:0] prio;
        logic [ID_W-1:0]    id;
        logic               grp;
    } cand_t;
endpackage

// File: rtl/psig_arbiter.sv
// Module: psig_arbiter
// Reduces the per-source eligibility and priority vectors to one winning
// candidate with a balanced binary tree. The left subtree always holds the
// lower indices and wins ties, so equal priorities resolve to the lower ID.
// Ineligible or padding leaves carry the sentinel priority 0x100.
// Assumes 2 <= NUM_SRC <= 1020.
module psig_arbiter
    import psig_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        eligible,
    input  logic [NUM_SRC-1:0]        grp,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    output cand_t                     best
);
    localparam int LVLS   = $clog2(NUM_SRC);
    localparam int LEAVES = 1 << LVLS;

    cand_t node [1:2*LEAVES-1];

    // Leaf stage: real sources or sentinels
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_SRC) begin : g_real
            assign node[LEAVES+i] = eligible[i]
                ? '{prio: {1'b0, prio[i*PRIO_W +: PRIO_W]}, id: ID_W'(i), grp: grp[i]}
                : '{prio: NO_PRIO, id: ID_W'(i), grp: 1'b0};
        end else begin : g_pad
            assign node[LEAVES+i] = '{prio: NO_PRIO, id: ID_W'(i), grp: 1'b0};
        end
    end

    // Internal stage: strictly better right child wins, otherwise the left one
    for (genvar k = 1; k < LEAVES; k++) begin : g_node
        assign node[k] = (node[2*k+1].prio < node[2*k].prio) ? node[2*k+1] : node[2*k];
    end

    assign best = node[1];

    // Any eligible source must yield a real priority (R2, R3)
    assert_found_when_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|eligible) |-> (best.prio != NO_PRIO));

    // No eligible source must yield the sentinel (R2)
    assert_sentinel_when_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(|eligible) |-> (best.prio == NO_PRIO));
endmodule

// File: rtl/psig_router.sv
// Module: psig_router
// Decides, from the winning candidate and the control bits, the next values
// of the two interrupt lines and of the pending ID. Purely combinational.
// Assumes the caller feeds back the registered pending ID so it can hold.
module psig_router
    import psig_pkg::*;
(
    input  cand_t             best,
    input  logic              dist_en_g0,
    input  logic              dist_en_g1,
    input  logic              cpu_en_g0,
    input  logic              cpu_en_g1,
    input  logic              cpu_fast_en,
    input  logic [PRIO_W-1:0] prio_mask,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic [ID_W-1:0]   pend_id_cur,
    output logic              irq_nxt,
    output logic              fiq_nxt,
    output logic [ID_W-1:0]   pend_id_nxt
);
    logic any_on;
    logic grp_on;
    logic below_mask;
    logic below_run;

    // Qualifying conditions for the winner
    always_comb begin
        any_on     = (dist_en_g0 | dist_en_g1) & (cpu_en_g0 | cpu_en_g1);
        grp_on     = best.grp ? (dist_en_g1 & cpu_en_g1) : (dist_en_g0 & cpu_en_g0);
        below_mask = best.prio < {1'b0, prio_mask};
        below_run  = best.prio < {1'b0, run_prio};
    end

    // Line selection and pending-ID update
    always_comb begin
        irq_nxt     = 1'b0;
        fiq_nxt     = 1'b0;
        pend_id_nxt = pend_id_cur;
        if (any_on) begin
            if (below_mask) begin
                pend_id_nxt = best.id;
                if (below_run && grp_on) begin
                    if (!best.grp && cpu_fast_en) fiq_nxt = 1'b1;
                    else                          irq_nxt = 1'b1;
                end
            end else begin
                pend_id_nxt = SPURIOUS_ID;
            end
        end
    end
endmodule

// File: rtl/psig_top.sv
// Module: psig_top
// Per-CPU grouped interrupt priority signaller. Qualifies sources, picks the
// most urgent one, routes it to the normal or fast line and registers the
// result (one cycle latency). Assumes synchronous active-low reset.
module psig_top
    import psig_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_pending,
    input  logic [NUM_SRC-1:0]        src_enable,
    input  logic [NUM_SRC-1:0]        src_target,
    input  logic [NUM_SRC-1:0]        src_group,
    input  logic [NUM_SRC*8-1:0]      src_prio,
    input  logic                      dist_en_g0,
    input  logic                      dist_en_g1,
    input  logic                      cpu_en_g0,
    input  logic                      cpu_en_g1,
    input  logic                      cpu_fast_en,
    input  logic [7:0]                prio_mask,
    input  logic [7:0]                run_prio,
    output logic                      irq_o,
    output logic                      fiq_o,
    output logic [9:0]                pend_id_o
);
    logic [NUM_SRC-1:0] eligible;
    cand_t              best;
    logic               irq_nxt;
    logic               fiq_nxt;
    logic [ID_W-1:0]    pend_id_nxt;
    logic               irq_q;
    logic               fiq_q;
    logic [ID_W-1:0]    pend_id_q;

    // Source qualification: pending, enabled and aimed at this CPU
    always_comb eligible = src_pending & src_enable & src_target;

    psig_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .eligible (eligible),
        .grp      (src_group),
        .prio     (src_prio),
        .best     (best)
    );

    psig_router u_route (
        .best        (best),
        .dist_en_g0  (dist_en_g0),
        .dist_en_g1  (dist_en_g1),
        .cpu_en_g0   (cpu_en_g0),
        .cpu_en_g1   (cpu_en_g1),
        .cpu_fast_en (cpu_fast_en),
        .prio_mask   (prio_mask),
        .run_prio    (run_prio),
        .pend_id_cur (pend_id_q),
        .irq_nxt     (irq_nxt),
        .fiq_nxt     (fiq_nxt),
        .pend_id_nxt (pend_id_nxt)
    );

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q     <= 1'b0;
            fiq_q     <= 1'b0;
            pend_id_q <= SPURIOUS_ID;
        end else begin
            irq_q     <= irq_nxt;
            fiq_q     <= fiq_nxt;
            pend_id_q <= pend_id_nxt;
        end
    end

    assign irq_o     = irq_q;
    assign fiq_o     = fiq_q;
    assign pend_id_o = pend_id_q;

    // Lines are mutually exclusive (R7)
    assert_lines_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_q && fiq_q));

    // Fast line only for a group-0 path with the fast enable set (R7, R6)
    assert_fast_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_q |-> $past(cpu_fast_en && dist_en_g0 && cpu_en_g0));

    // All groups off at either level silences both lines and holds the ID (R8)
    assert_all_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(dist_en_g0 | dist_en_g1) || !(cpu_en_g0 | cpu_en_g1))
        |=> (!irq_q && !fiq_q && $stable(pend_id_q)));

    // A raised line always comes with a real pending ID (R4, R5)
    assert_line_has_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q || fiq_q) |-> (pend_id_q != SPURIOUS_ID));

    // A raised line needs some CPU-interface group enabled a cycle earlier (R6)
    assert_line_needs_cpu_grp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q || fiq_q) |-> $past(cpu_en_g0 || cpu_en_g1));
endmodule

// File: tb/tb_psig_top.sv
`timescale 1ns/1ps
module tb_psig_top;
    localparam int N = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    pend, en, tgt, grp;
    logic [N*8-1:0]  prio;
    logic            dg0, dg1, cg0, cg1, fast;
    logic [7:0]      mask, run;
    logic            irq, fiq;
    logic [9:0]      pid;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    psig_top #(.NUM_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .src_pending(pend), .src_enable(en), .src_target(tgt), .src_group(grp),
        .src_prio(prio),
        .dist_en_g0(dg0), .dist_en_g1(dg1), .cpu_en_g0(cg0), .cpu_en_g1(cg1),
        .cpu_fast_en(fast), .prio_mask(mask), .run_prio(run),
        .irq_o(irq), .fiq_o(fiq), .pend_id_o(pid)
    );

    task automatic check(input string req, input logic ei, input logic ef, input int eid);
        n_chk++;
        if (irq !== ei || fiq !== ef || pid !== 10'(eid)) begin
            n_fail++;
            $display("FAIL %s: irq/fiq/id = %0b/%0b/%0d, expected %0b/%0b/%0d",
                     req, irq, fiq, pid, ei, ef, eid);
        end
    endtask

    // Wait one rising edge, sample at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        pend = '0; en = '0; tgt = '0; grp = '0; prio = '1;
        dg0 = 1; dg1 = 1; cg0 = 1; cg1 = 1; fast = 0;
        mask = 8'hFF; run = 8'hFF;
    endtask

    task automatic add_src(input int i, input logic [7:0] p, input logic g);
        pend[i] = 1; en[i] = 1; tgt[i] = 1; grp[i] = g;
        prio[i*8 +: 8] = p;
    endtask

    task automatic t_reset();
        rst_n = 0; clear_all();
        add_src(5, 8'h10, 1'b1);
        step(); step();
        check("R1 reset state", 0, 0, 1023);
        rst_n = 1;
    endtask

    task automatic t_idle();
        clear_all(); step();
        check("R4 no eligible source", 0, 0, 1023);
    endtask

    task automatic t_eligible();
        clear_all(); add_src(5, 8'h40, 1'b1); step();
        check("R2 single source", 1, 0, 5);
        pend[3] = 1; tgt[3] = 1; en[3] = 0; prio[3*8 +: 8] = 8'h10; step();
        check("R2 disabled source ignored", 1, 0, 5);
        en[3] = 1; tgt[3] = 0; step();
        check("R2 untargeted source ignored", 1, 0, 5);
        tgt[3] = 1; pend[3] = 0; step();
        check("R2 non-pending source ignored", 1, 0, 5);
        pend[3] = 1; step();
        check("R2 fully eligible source wins", 1, 0, 3);
    endtask

    task automatic t_order();
        clear_all();
        add_src(7, 8'h20, 1); add_src(2, 8'h20, 1); add_src(20, 8'h21, 1); step();
        check("R3 tie goes to lower index", 1, 0, 2);
        pend[2] = 0; step();
        check("R3 next best", 1, 0, 7);
        add_src(30, 8'h01, 1); step();
        check("R3 smaller value wins", 1, 0, 30);
        add_src(31, 8'h00, 1); step();
        check("R3 top index with priority 0", 1, 0, 31);
        add_src(0, 8'h00, 1); step();
        check("R3 tie at priority 0 to index 0", 1, 0, 0);
    endtask

    task automatic t_mask();
        clear_all(); add_src(30, 8'h01, 1);
        mask = 8'h01; step();
        check("R4 priority equal to mask", 0, 0, 1023);
        mask = 8'h02; step();
        check("R4 priority below mask", 1, 0, 30);
        mask = 8'h00; step();
        check("R4 mask zero blocks all", 0, 0, 1023);
        mask = 8'hFF; prio[30*8 +: 8] = 8'hFF; step();
        check("R4 priority 0xFF never below mask", 0, 0, 1023);
    endtask

    task automatic t_run();
        clear_all(); add_src(30, 8'h10, 1);
        run = 8'h10; step();
        check("R5 equal to running priority", 0, 0, 30);
        run = 8'h11; step();
        check("R5 below running priority", 1, 0, 30);
        run = 8'h00; step();
        check("R5 running priority zero", 0, 0, 30);
    endtask

    task automatic t_route();
        clear_all(); add_src(30, 8'h10, 0); step();
        check("R7 group 0 without fast enable", 1, 0, 30);
        fast = 1; step();
        check("R7 group 0 with fast enable", 0, 1, 30);
        grp[30] = 1; step();
        check("R7 group 1 ignores fast enable", 1, 0, 30);
        add_src(4, 8'h08, 0); step();
        check("R7 group 0 winner over group 1", 0, 1, 4);
    endtask

    task automatic t_gate();
        clear_all(); add_src(9, 8'h10, 0); fast = 1;
        dg0 = 0; step();
        check("R6 distributor group 0 off", 0, 0, 9);
        dg0 = 1; cg0 = 0; step();
        check("R6 cpu group 0 off", 0, 0, 9);
        cg0 = 1; grp[9] = 1; dg1 = 0; step();
        check("R6 distributor group 1 off", 0, 0, 9);
        dg1 = 1; cg1 = 0; step();
        check("R6 cpu group 1 off", 0, 0, 9);
        cg1 = 1; step();
        check("R6 both levels on", 1, 0, 9);
    endtask

    task automatic t_off();
        clear_all(); add_src(9, 8'h10, 1); step();
        check("R8 baseline", 1, 0, 9);
        dg0 = 0; dg1 = 0; add_src(1, 8'h05, 1); step();
        check("R8 distributor off holds ID", 0, 0, 9);
        dg0 = 1; dg1 = 1; cg0 = 0; cg1 = 0; step();
        check("R8 cpu interface off holds ID", 0, 0, 9);
        cg0 = 1; cg1 = 1; step();
        check("R8 re-enabled", 1, 0, 1);
    endtask

    task automatic t_latency();
        clear_all(); add_src(6, 8'h10, 1); step();
        check("R9 settled", 1, 0, 6);
        pend[6] = 0;
        #3;
        check("R9 unchanged before edge", 1, 0, 6);
        @(posedge clk); #1;
        check("R9 updated after one edge", 0, 0, 1023);
        @(negedge clk);
        add_src(6, 8'h10, 1); step();
        rst_n = 0; step();
        check("R1 reset while active", 0, 0, 1023);
        rst_n = 1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout, expected completion");
        finish_run();
    end

    initial begin
        clear_all(); rst_n = 0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_eligible();
        t_order();
        t_mask();
        t_run();
        t_route();
        t_gate();
        t_off();
        t_latency();
        finish_run();
    end
endmodule